// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes one host request at a time and turns it into a complete, legal command sequence for one bank. The sequence opens a row, writes a burst starting at a column, and closes the row again. The host chooses how the write burst ends. It can run to its natural length. It can be cut short by a READ to the same column, in which case one read word is returned to the host. It can be cut short by a PRECHARGE, in which case the data mask hides the burst slots that are left.

Whatever the ending, the block counts write recovery before closing the row and row-precharge time before it will accept the next request. It drives a NOP on every cycle that carries no command. A ready/valid pair paces the host. The block accepts a request only in its idle state. While busy, it ignores whatever appears on the request inputs.

The state machine has these states and transitions:

- IDLE moves to ACT when a request is accepted.
- ACT moves to RCD, which waits out the activate-to-column delay and then moves to WR.
- WR moves to BURST when more than one word is to be written. Otherwise it goes straight to the burst-end step.
- BURST moves to the burst-end step after the last desired word.
- At the burst-end step, the READ-cut mode goes to RD, then RDLAT, then PRE. Every other mode goes to WREC, then PRE.
- PRE moves to RP, and RP returns to IDLE.

Top module: `wterm_seq`

## Requirements
- R1: After reset, and whenever idle, the command pins {cs_n, ras_n, cas_n, we_n} read 0111 (NOP), `req_ready` is 1, the data driver and data mask are 0, and `rd_valid` is 0.
- R2: An accepted request drives ACTIVE (0011) with the request row and bank on the next cycle. T_RCD-1 NOP cycles follow, and then WRITE (0100) with the column on the low address bits, address bit 10 at 0, and the same bank.
- R3: `sd_dq_oe` and `wr_take` are both high on exactly N consecutive cycles starting with the WRITE cycle, and `sd_dq_out` equals `wr_data` on those cycles. Mode is 00 = full burst, 01 = READ cut, 10 = PRECHARGE cut, 11 = full burst. For modes 00 and 11, N = BURST_LEN. For modes 01 and 10, N = `req_len`, except that a length of 0 or above BURST_LEN means BURST_LEN.
- R4: In mode 01, READ (0101) is issued on the cycle after the last data cycle, with the same bank and column and address bit 10 at 0. The data driver is low from the READ cycle on.
- R5: In mode 01, `sd_dq_in` is sampled in the cycle CAS_LAT cycles after the READ. It is presented on `rd_data` with a single-cycle `rd_valid` pulse on the following cycle.
- R6: PRECHARGE (0010, address bit 10 at 0, same bank) is issued T_WR cycles after the last data cycle in modes 00, 10 and 11. In mode 01 it is issued max(CAS_LAT, T_WR-2)+1 cycles after the READ. It is never issued less than T_WR cycles after the last data cycle.
- R7: In mode 10, the data mask is high on every cycle after the last data cycle up to and including the PRECHARGE cycle. In all other cycles and modes it is low.
- R8: PRECHARGE is followed by T_RP-1 NOP cycles. The block is idle again T_RP cycles after PRECHARGE, so the next ACTIVE comes no sooner than T_RP+1 cycles after it.
- R9: `req_ready` is low from acceptance until the return to idle. Request inputs presented while busy change nothing in the running sequence.
- R10: Cycle counts are derived at elaboration from the clock period by rounding up. T_WR = 1 clock + ceil(8 ns / period), T_RP = ceil(tRP / period), T_RCD = ceil(tRCD / period), each at least 2. At 100 MHz with 20 ns tRP and tRCD, all three are 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Start column for write and read |
| req_len | input | LEN_W | Desired word count for cut modes |
| req_mode | input | 2 | Burst ending: 00 full, 01 READ cut, 10 PRECHARGE cut, 11 full |
| wr_data | input | DQ_W | Write word for the current data cycle |
| wr_take | output | 1 | Current `wr_data` is driven to the memory this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dmask | output | DQ_W/8 | Data mask, one bit per byte lane |
| sd_dq_oe | output | 1 | Data bus driver enable |
| sd_dq_out | output | DQ_W | Data driven to the memory |
| sd_dq_in | input | DQ_W | Data returned by the memory |
| rd_valid | output | 1 | `rd_data` holds the captured read word |
| rd_data | output | DQ_W | Captured read word |

## Verification
Under the default timing, two events fall on the same cycle in READ-cut mode. The captured read word is handed to the host on exactly the cycle that PRECHARGE goes out. In PRECHARGE-cut mode, the mask that hides the leftover burst slots is still asserted on the PRECHARGE cycle itself.

The bench provokes both cases with directed one-word and full-length requests in each mode, and then with seeded random requests. Some of these hold a random request on the inputs during the busy window. The bench drives the memory data input with a known word only on the cycle the read word is due, and with noise on every other cycle. On every cycle it compares the command, address, mask, driver enable, ready and read-return outputs against a cycle trace it predicts from the requirements.

// File: rtl/wterm_pkg.sv
`timescale 1ns/1ps
package wterm_pkg;

    // Command pins ordered {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'b00,
        MODE_RD_CUT  = 2'b01,
        MODE_PRE_CUT = 2'b10,
        MODE_FULL_B  = 2'b11
    } term_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ACT, ST_RCD, ST_WR, ST_BURST,
        ST_WREC, ST_RD, ST_RDLAT, ST_PRE, ST_RP
    } seq_st_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wterm_timer.sv
`timescale 1ns/1ps
module wterm_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wterm_pin_drv.sv
`timescale 1ns/1ps
module wterm_pin_drv
    import wterm_pkg::*;
(
    input  sd_cmd_e cmd,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n
);
    assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/wterm_seq.sv
`timescale 1ns/1ps
module wterm_seq
    import wterm_pkg::*;
#(
    parameter int DQ_W         = 16,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 8,
    parameter int BA_W         = 2,
    parameter int BURST_LEN    = 4,
    parameter int CAS_LAT      = 2,
    parameter int AP_BIT       = 10,
    parameter int CLK_PS       = 10000,
    parameter int TWR_EXTRA_PS = 8000,
    parameter int TRP_PS       = 20000,
    parameter int TRCD_PS      = 20000,
    parameter int LEN_W        = $clog2(BURST_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic [1:0]       req_mode,
    input  logic [DQ_W-1:0]  wr_data,
    output logic             wr_take,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic [DQ_W/8-1:0] sd_dmask,
    output logic             sd_dq_oe,
    output logic [DQ_W-1:0]  sd_dq_out,
    input  logic [DQ_W-1:0]  sd_dq_in,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data
);
    localparam int DQM_W    = DQ_W / 8;
    localparam int T_WR_CYC = max2(2, 1 + ceil_div(TWR_EXTRA_PS, CLK_PS));
    localparam int T_RP_CYC = max2(2, ceil_div(TRP_PS, CLK_PS));
    localparam int T_RCD_CYC = max2(2, ceil_div(TRCD_PS, CLK_PS));
    // READ-cut wait also has to cover write recovery before PRECHARGE
    localparam int RD_HOLD  = max2(CAS_LAT, T_WR_CYC - 2);
    localparam int TMR_MAX  = max2(max2(BURST_LEN, RD_HOLD),
                                   max2(T_WR_CYC, max2(T_RP_CYC, T_RCD_CYC)));
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int CAP_AT   = RD_HOLD - CAS_LAT;

    seq_st_e st, st_n;

    logic [BA_W-1:0]  bank_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] words_q, words_d;
    logic             rd_cut_q, pre_cut_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val, tmr_cnt;
    logic             tmr_zero;

    sd_cmd_e          cmd;
    logic             mask_on;

    // ---------------- request decode ----------------
    always_comb begin
        if (!(req_mode == MODE_RD_CUT || req_mode == MODE_PRE_CUT) ||
            req_len == '0 || req_len > LEN_W'(BURST_LEN)) begin
            words_d = LEN_W'(BURST_LEN);
        end else begin
            words_d = req_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
            words_q   <= '0;
            rd_cut_q  <= 1'b0;
            pre_cut_q <= 1'b0;
        end else if (st == ST_IDLE && req_valid) begin
            bank_q    <= req_bank;
            row_q     <= req_row;
            col_q     <= req_col;
            words_q   <= words_d;
            rd_cut_q  <= (req_mode == MODE_RD_CUT);
            pre_cut_q <= (req_mode == MODE_PRE_CUT);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_n = ST_ACT;
            ST_ACT:   st_n = ST_RCD;
            ST_RCD:   if (tmr_zero) st_n = ST_WR;
            ST_WR: begin
                if (words_q > LEN_W'(1)) st_n = ST_BURST;
                else                     st_n = rd_cut_q ? ST_RD : ST_WREC;
            end
            ST_BURST: if (tmr_zero) st_n = rd_cut_q ? ST_RD : ST_WREC;
            ST_WREC:  if (tmr_zero) st_n = ST_PRE;
            ST_RD:    st_n = ST_RDLAT;
            ST_RDLAT: if (tmr_zero) st_n = ST_PRE;
            ST_PRE:   st_n = ST_RP;
            ST_RP:    if (tmr_zero) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // Timer loaded on entry with (cycles to stay in the state) - 1
    assign tmr_load = (st_n != st);
    always_comb begin
        unique case (st_n)
            ST_RCD:   tmr_val = TMR_W'(T_RCD_CYC - 2);
            ST_BURST: tmr_val = TMR_W'(words_q) - TMR_W'(2);
            ST_WREC:  tmr_val = TMR_W'(T_WR_CYC - 2);
            ST_RDLAT: tmr_val = TMR_W'(RD_HOLD - 1);
            ST_RP:    tmr_val = TMR_W'(T_RP_CYC - 2);
            default:  tmr_val = '0;
        endcase
    end

    wterm_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .zero     (tmr_zero)
    );

    // ---------------- outputs ----------------
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        sd_dq_oe  = 1'b0;
        wr_take   = 1'b0;
        mask_on   = 1'b0;
        req_ready = 1'b0;
        unique case (st)
            ST_IDLE:  req_ready = 1'b1;
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_addr = row_q;
            end
            ST_WR: begin
                cmd      = CMD_WR;
                sd_addr  = ROW_W'(col_q);
                sd_addr[AP_BIT] = 1'b0;
                sd_dq_oe = 1'b1;
                wr_take  = 1'b1;
            end
            ST_BURST: begin
                sd_dq_oe = 1'b1;
                wr_take  = 1'b1;
            end
            ST_WREC:  mask_on = pre_cut_q;
            ST_RD: begin
                cmd     = CMD_RD;
                sd_addr = ROW_W'(col_q);
                sd_addr[AP_BIT] = 1'b0;
            end
            ST_PRE: begin
                cmd     = CMD_PRE;
                mask_on = pre_cut_q;
            end
            default: ;
        endcase
    end

    assign sd_ba     = bank_q;
    assign sd_dmask  = {DQM_W{mask_on}};
    assign sd_dq_out = sd_dq_oe ? wr_data : '0;

    wterm_pin_drv u_pins (
        .cmd   (cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    // ---------------- read word capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (st == ST_RDLAT) && (tmr_cnt == TMR_W'(CAP_AT));
            if ((st == ST_RDLAT) && (tmr_cnt == TMR_W'(CAP_AT))) begin
                rd_data <= sd_dq_in;
            end
        end
    end
endmodule

// File: rtl/wterm_seq_chk.sv
`timescale 1ns/1ps
module wterm_seq_chk #(
    parameter int T_WR  = 2,
    parameter int T_RP  = 2,
    parameter int DQM_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic [DQM_W-1:0] dmask,
    input logic             rd_valid
);
    logic [3:0] pins;
    logic [7:0] since_data, since_pre;
    logic       mask_any;

    assign pins     = {cs_n, ras_n, cas_n, we_n};
    assign mask_any = |dmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_data <= 8'hFF;
            since_pre  <= 8'hFF;
        end else begin
            if (dq_oe)                   since_data <= 8'd1;
            else if (since_data != 8'hFF) since_data <= since_data + 8'd1;
            if (pins == 4'b0010)         since_pre <= 8'd1;
            else if (since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
        end
    end

    AST_ACCEPT_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (pins == 4'b0011)); // R2
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0101) |-> !dq_oe); // R4
    AST_READ_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0101) |-> $past(dq_oe)); // R4
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5
    AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> (since_data >= 8'(T_WR))); // R6
    AST_PRE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins == 4'b0010) && mask_any) |-> $past(mask_any)); // R7
    AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0011) |-> (since_pre > 8'(T_RP))); // R8
    AST_BUSY_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && pins != 4'b0010) |=> (pins != 4'b0011)); // R9
endmodule

bind wterm_seq wterm_seq_chk #(
    .T_WR  (T_WR_CYC),
    .T_RP  (T_RP_CYC),
    .DQM_W (DQM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .dq_oe     (sd_dq_oe),
    .dmask     (sd_dmask),
    .rd_valid  (rd_valid)
);

// File: tb/wterm_seq_bench.sv
`timescale 1ns/1ps
module wterm_seq_bench;
    // Expected timing at 100 MHz (R10): 1 clk + ceil(8/10) = 2, ceil(20/10) = 2
    localparam int T_WR  = 2;
    localparam int T_RP  = 2;
    localparam int T_RCD = 2;
    localparam int CL    = 2;
    localparam int BL    = 4;
    localparam int RDH   = (CL > T_WR - 2) ? CL : T_WR - 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [2:0]  req_len = '0;
    logic [1:0]  req_mode = '0;
    logic [15:0] wr_data = '0;
    logic        wr_take;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dmask;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = '0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    wterm_seq u_wterm_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_len(req_len), .req_mode(req_mode), .wr_data(wr_data),
        .wr_take(wr_take), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dmask(sd_dmask), .sd_dq_oe(sd_dq_oe),
        .sd_dq_out(sd_dq_out), .sd_dq_in(sd_dq_in), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_words(input logic [1:0] mode, input logic [2:0] len);
        if (mode == 2'b01 || mode == 2'b10)
            return (len == 0 || len > BL) ? BL : int'(len);
        return BL;
    endfunction

    function automatic logic [3:0] exp_cmd(input int t, input int w, input int r,
                                           input int p, input logic [1:0] mode);
        if (t == 1)                   return 4'b0011;
        if (t == w)                   return 4'b0100;
        if (mode == 2'b01 && t == r)  return 4'b0101;
        if (t == p)                   return 4'b0010;
        return 4'b0111;
    endfunction

    task automatic idle_check(input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk("R1", "idle cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
            chk("R1", "idle ready", req_ready, 1'b1);
            chk("R1", "idle oe", sd_dq_oe, 1'b0);
            chk("R1", "idle mask", sd_dmask, 2'b00);
            chk("R1", "idle rd_valid", rd_valid, 1'b0);
        end
    endtask

    // Entered at a negedge (+1) of an idle cycle; leaves in the first idle cycle after.
    task automatic run_txn(input logic [1:0] mode, input logic [2:0] len,
                           input logic [1:0] bank, input logic [11:0] row,
                           input logic [7:0] col, input bit noise);
        int n, w, k, r, p, end_t;
        logic [15:0] rd_word;
        logic [3:0]  ec;
        string       tag;
        n = exp_words(mode, len);
        w = 1 + T_RCD;
        k = w + n - 1;
        r = k + 1;
        p = (mode == 2'b01) ? k + 2 + RDH : k + T_WR;
        end_t = p + T_RP;
        rd_word = 16'($urandom);
        req_valid = 1'b1;
        req_mode = mode; req_len = len; req_bank = bank; req_row = row; req_col = col;
        @(posedge clk);
        for (int t = 1; t <= end_t; t++) begin
            @(negedge clk);
            wr_data  = 16'($urandom);
            sd_dq_in = (mode == 2'b01 && t == r + CL) ? rd_word : 16'($urandom);
            if (noise && t < end_t) begin
                req_valid = 1'($urandom);
                req_mode = 2'($urandom); req_len = 3'($urandom);
                req_bank = 2'($urandom); req_row = 12'($urandom); req_col = 8'($urandom);
            end else begin
                req_valid = 1'b0;
            end
            #1;
            ec  = exp_cmd(t, w, r, p, mode);
            tag = (t == 1 || t == w) ? "R2" : (mode == 2'b01 && t == r) ? "R4" :
                  (t == p) ? "R6" : (t > p) ? "R8" : "R9";
            chk(tag, "cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, ec);
            if (t == 1) begin
                chk("R2", "act row", sd_addr, row);
                chk("R2", "act bank", sd_ba, bank);
            end
            if (t == w || (mode == 2'b01 && t == r)) begin
                chk(t == w ? "R2" : "R4", "col addr", sd_addr, {4'b0000, col});
                chk(t == w ? "R2" : "R4", "col bank", sd_ba, bank);
            end
            if (t == p) begin
                chk("R6", "pre a10", sd_addr[10], 1'b0);
                chk("R6", "pre bank", sd_ba, bank);
            end
            chk("R3", "oe", sd_dq_oe, (t >= w && t <= k));
            chk("R3", "take", wr_take, (t >= w && t <= k));
            if (t >= w && t <= k) chk("R3", "dq_out", sd_dq_out, wr_data);
            chk("R7", "mask", sd_dmask, (mode == 2'b10 && t > k && t <= p) ? 2'b11 : 2'b00);
            chk(t == end_t ? "R8" : "R9", "ready", req_ready, (t == end_t));
            chk("R5", "rd_valid", rd_valid, (mode == 2'b01 && t == r + CL + 1));
            if (mode == 2'b01 && t == r + CL + 1) chk("R5", "rd_data", rd_data, rd_word);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_check(2);                                  // R1 reset state
        // directed corners
        run_txn(2'b00, 3'd1, 2'd1, 12'h5A5, 8'h12, 0);  // R3 full burst ignores len
        run_txn(2'b01, 3'd1, 2'd2, 12'h0F0, 8'hFF, 0);  // R4 R5 one word then READ
        run_txn(2'b10, 3'd1, 2'd3, 12'hFFF, 8'h00, 0);  // R7 one word, mask rest
        run_txn(2'b10, 3'd2, 2'd0, 12'h123, 8'h40, 0);  // R7 R6 two words
        run_txn(2'b01, 3'd4, 2'd1, 12'h321, 8'h80, 0);  // R5 full length then READ
        run_txn(2'b01, 3'd0, 2'd2, 12'h777, 8'h07, 0);  // R3 len 0 means BURST_LEN
        run_txn(2'b10, 3'd7, 2'd3, 12'h888, 8'h09, 1);  // R3 len above BURST_LEN, R9 noise
        run_txn(2'b11, 3'd2, 2'd0, 12'h444, 8'h33, 1);  // R3 mode 11 full burst
        run_txn(2'b01, 3'd3, 2'd1, 12'h222, 8'h55, 1);  // R8 back-to-back start
        idle_check(1);
        // seeded random mix
        for (int i = 0; i < 60; i++) begin
            run_txn(2'($urandom), 3'($urandom), 2'($urandom), 12'($urandom),
                    8'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) idle_check(1 + $urandom % 3);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule